// File: doc/BRIEF.md
# Serial Ones-Count Modulo-3 Detector

This block watches a serial one-bit stream and keeps the number of 1 bits seen since reset, reduced modulo three. A single flag output is high whenever that running count is an exact multiple of three. The flag includes the case of zero ones counted.

The block is a Moore machine with three states, one for each remainder. The flag depends only on the current state and never directly on the input. The 2-bit state is also brought out so that the surrounding logic can see which remainder is current. Each rising clock edge samples one input bit. The state updated at that edge is visible on the outputs for the cycle that follows.

Top module: `mod3_ones_detector`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `state_o` is 2'b00 and `flag_o` is 1. Asserting `rst_ni` low between clock edges clears the state at once, without waiting for an edge.
- R2: `state_o` encodes the remainder of the ones count: 2'b00 means remainder 0, 2'b01 means remainder 1 and 2'b10 means remainder 2.
- R3: When `data_i` is 1 at a rising edge, the remainder advances cyclically at that edge: 0 to 1, 1 to 2, and 2 to 0.
- R4: When `data_i` is 0 at a rising edge, the state is unchanged, however long the run of zeros lasts.
- R5: `flag_o` is 1 exactly when the state is remainder 0. It changes only when the state changes.
- R6: `state_o` never shows the unused code 2'b11. If that code ever appears, the next edge returns the state to remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the input is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data bit |
| flag_o | output | 1 | High when the ones count is a multiple of three |
| state_o | output | 2 | Current remainder code |

## Verification
The bench goes after the wrap from remainder 2 back to 0. A design that got this wrong would stall at 2, or would step into the unused 11 code and raise the flag a cycle late or never.

Long runs of zeros at each remainder are checked for drift. A machine that also counted zeros, or advanced on every edge, would move the state during such a run.

Reset is pulled low mid-stream between clock edges. A reset that waits for the clock, or that restores a remainder other than 0, shows a stale state and a low flag.

The flag is checked in every cycle against the state the bench expects. A flag decoded from the input instead of the state would lead or lag by one cycle.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int unsigned REM_W = 2;

  typedef enum logic [REM_W-1:0] {
    REM0   = 2'b00,
    REM1   = 2'b01,
    REM2   = 2'b10,
    REM_NA = 2'b11
  } rem_e;
endpackage

// File: rtl/mod3_next.sv
module mod3_next
  import mod3_pkg::*;
(
  input  rem_e state_i,
  input  logic data_i,
  output rem_e state_o
);
  always_comb begin
    unique case (state_i)
      REM0:    state_o = data_i ? REM1 : REM0;
      REM1:    state_o = data_i ? REM2 : REM1;
      REM2:    state_o = data_i ? REM0 : REM2;
      default: state_o = REM0; // unused code recovers
    endcase
  end
endmodule

// File: rtl/mod3_state_reg.sv
module mod3_state_reg
  import mod3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  rem_e state_d,
  output rem_e state_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REM0;
    else         state_q <= state_d;
  end

  AST_ONE_FROM_REM0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i && state_q == REM0) |=> state_q == REM1); // R3
  AST_ONE_FROM_REM1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i && state_q == REM1) |=> state_q == REM2); // R3
  AST_ONE_FROM_REM2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i && state_q == REM2) |=> state_q == REM0); // R3
  AST_ZERO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_i && state_q != REM_NA) |=> $stable(state_q)); // R4
  AST_NO_UNUSED_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != REM_NA); // R6
  AST_UNUSED_RECOVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == REM_NA |=> state_q == REM0); // R6
endmodule

// File: rtl/mod3_flag.sv
module mod3_flag
  import mod3_pkg::*;
(
  input  rem_e state_i,
  output logic flag_o
);
  assign flag_o = (state_i == REM0);
endmodule

// File: rtl/mod3_ones_detector.sv
module mod3_ones_detector
  import mod3_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  output logic             flag_o,
  output logic [REM_W-1:0] state_o
);
  rem_e state_d, state_q;

  mod3_next u_next (
    .state_i (state_q),
    .data_i  (data_i),
    .state_o (state_d)
  );

  mod3_state_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .state_d (state_d),
    .state_q (state_q)
  );

  mod3_flag u_flag (
    .state_i (state_q),
    .flag_o  (flag_o)
  );

  assign state_o = state_q;

  AST_FLAG_FOLLOWS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(state_o) |-> $stable(flag_o)); // R5
  AST_FLAG_ON_REM0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00) |-> flag_o); // R5
  AST_FLAG_OFF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'b00) |-> !flag_o); // R5
endmodule

// File: tb/tb_mod3_ones_detector.sv
`timescale 1ns/1ps
module tb_mod3_ones_detector;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic       flag_o;
  logic [1:0] state_o;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  mod3_ones_detector dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .flag_o  (flag_o),
    .state_o (state_o)
  );

  // {data bit, expected state after the edge}
  localparam logic [2:0] VEC [16] = '{
    {1'b1, 2'b01}, {1'b0, 2'b01}, {1'b1, 2'b10}, {1'b1, 2'b00},
    {1'b0, 2'b00}, {1'b0, 2'b00}, {1'b1, 2'b01}, {1'b1, 2'b10},
    {1'b0, 2'b10}, {1'b1, 2'b00}, {1'b1, 2'b01}, {1'b0, 2'b01},
    {1'b1, 2'b10}, {1'b0, 2'b10}, {1'b1, 2'b00}, {1'b1, 2'b01}
  };

  task automatic check(input string req, input logic [1:0] exp_state);
    logic exp_flag;
    exp_flag = (exp_state == 2'b00);
    checks++;
    if (state_o !== exp_state || flag_o !== exp_flag) begin
      errors++;
      $display("FAIL %s: state=%b flag=%b expected state=%b flag=%b",
               req, state_o, flag_o, exp_state, exp_flag);
    end
  endtask

  task automatic step(input logic d);
    @(negedge clk_i);
    data_i = d;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #100us;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    check("R1 in reset", 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0);
    check("R1 after release", 2'b00);

    // R2 R3 R4 R5: vector walk
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][2]);
      check("R2/R3/R4/R5 vector", VEC[i][1:0]);
    end

    // R4: long zero run at remainder 1 (state now 01)
    for (int i = 0; i < 10; i++) begin
      step(1'b0);
      check("R4 zero run rem1", 2'b01);
    end
    step(1'b1);
    for (int i = 0; i < 6; i++) begin
      step(1'b0);
      check("R4 zero run rem2", 2'b10);
    end

    // R3 R6: all-ones run wraps, never 11
    for (int i = 0; i < 9; i++) begin
      step(1'b1);
      check("R3/R6 ones run", 2'((i + 3) % 3));
    end

    // R1: asynchronous reset mid-stream (state now 10 after 9 ones from 10)
    step(1'b1);
    check("R3 wrap before reset", 2'b00);
    step(1'b1);
    @(negedge clk_i);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    data_i = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1/R3 resume after reset", 2'b01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule